// File: doc/BRIEF.md
# Averaging Deadband Control Digitizer

This block turns the raw conversion stream from a potentiometer ADC into a steady target length for a sample buffer. A knob read directly through an ADC wobbles by a few codes from one conversion to the next. If that noise reached a buffer-length register, the length would twitch constantly. The block averages a fixed block of conversions, scales the average to the output width and applies a lower floor. It then moves its stored target only when the new value has moved far enough away from the stored one.

Each conversion arrives as an unsigned 10-bit code with a one-cycle strobe. After every 256 strobes the block forms a candidate length: the conversion sum divided by four. A candidate under 0x0200 is raised to 0x0200. The candidate is compared with the stored target, and a difference of 0x40 or more in either direction replaces the target. The value written always has bit 0 cleared, so the length is even. A single-cycle pulse marks every replacement, so downstream logic can react without comparing values itself.

Top module: `pot_length_filter`

## Requirements
- R1: Each cycle with `adcValid` high adds the unsigned 10-bit `adcData` to a running sum that is at least 18 bits wide. A block of 256 full-scale codes (1023) yields the candidate 0xFFC0 with no wrap.
- R2: The candidate is formed only when the 256th strobe of a block has been taken, and it equals the block sum shifted right by 2. After 255 strobes the target stays unchanged for as long as no further strobe arrives.
- R3: A candidate below 0x0200 is replaced by 0x0200 before the comparison. `targetLen` is never below 0x0200.
- R4: The target is replaced only when the absolute difference between the floored candidate and the stored target is 0x40 or more. This holds whether the candidate is above or below the target. A difference of 0x3F leaves the target unchanged.
- R5: A value written into the target has bit 0 cleared.
- R6: The sum and the strobe count restart after every block, whether or not the target was replaced.
- R7: After reset `targetLen` is 0x0600 and `targetUpd` is low.
- R8: `targetUpd` is high for exactly the one cycle in which `targetLen` first shows a new value. It is low in every other cycle.
- R9: The target changes at the second rising edge after the edge that takes the 256th strobe. A strobe in the cycle between those two edges counts as the first conversion of the next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adcValid | input | 1 | One-cycle strobe for a finished conversion |
| adcData | input | 10 | Unsigned conversion result, valid with adcValid |
| targetLen | output | 16 | Stored target buffer length |
| targetUpd | output | 1 | One-cycle pulse when targetLen takes a new value |

## Verification
The bench builds the block with its default parameters: 10-bit codes, 256-conversion blocks, 16-bit output, a floor of 0x0200, a deadband of 0x40 and a reset value of 0x0600. With these values, full-scale input reaches the top of the 18-bit sum. A single code altered in one sample of a block shifts the candidate by one output step, so the bench can place candidates exactly 0x3F and 0x40 away from the stored target, and on an odd value. A continuous strobe stream reaches the evaluation cycle with a strobe already present, which exercises how conversions fold into the next block.

// File: rtl/pot_length_pkg.sv
package pot_length_pkg;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic accAdd;    // add the current code to the running sum
    logic accLoad;   // start a new sum with the current code
    logic evaluate;  // block complete: judge the candidate, restart the sum
  } ctlStrobes_t;

endpackage

// File: rtl/pot_length_ctrl.sv
module pot_length_ctrl #(
  parameter int unsigned LOG_SAMPLES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adcValid,
  output pot_length_pkg::ctlStrobes_t strobes
);

  localparam logic [LOG_SAMPLES-1:0] LAST_IDX = {LOG_SAMPLES{1'b1}};

  logic [LOG_SAMPLES-1:0] sampleCnt;
  logic                   evalPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      evalPend  <= 1'b0;
    end else begin
      evalPend <= adcValid && (sampleCnt == LAST_IDX);
      if (adcValid) begin
        sampleCnt <= sampleCnt + 1'b1;  // wraps to zero at block end
      end
    end
  end

  always_comb begin
    strobes.evaluate = evalPend;
    strobes.accLoad  = evalPend && adcValid;
    strobes.accAdd   = !evalPend && adcValid;
  end

endmodule

// File: rtl/pot_length_dpath.sv
module pot_length_dpath #(
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned LOG_SAMPLES = 8,
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned MIN_LEN     = 'h0200,
  parameter int unsigned DEADBAND    = 'h0040,
  parameter int unsigned RESET_LEN   = 'h0600
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADC_W-1:0]            adcData,
  input  pot_length_pkg::ctlStrobes_t strobes,
  output logic [OUT_W-1:0]            targetLen,
  output logic                        targetUpd
);

  localparam int unsigned ACC_W = ADC_W + LOG_SAMPLES;
  localparam int unsigned SHIFT = ACC_W - OUT_W;
  localparam logic [OUT_W-1:0] FLOOR_V = OUT_W'(MIN_LEN);
  localparam logic [OUT_W-1:0] BAND_V  = OUT_W'(DEADBAND);
  localparam logic [OUT_W-1:0] INIT_V  = OUT_W'(RESET_LEN);

  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accShifted;
  logic [OUT_W-1:0] candRaw;
  logic [OUT_W-1:0] candFloored;
  logic [OUT_W-1:0] candEven;
  logic [OUT_W-1:0] absDiff;
  logic             takeCand;

  // Running sum of one block of conversions.
  always_ff @(posedge clk) begin
    if (rst) begin
      accSum <= '0;
    end else if (strobes.accLoad) begin
      accSum <= ACC_W'(adcData);
    end else if (strobes.evaluate) begin
      accSum <= '0;
    end else if (strobes.accAdd) begin
      accSum <= accSum + ACC_W'(adcData);
    end
  end

  // Candidate formation: scale, floor, force even, measure distance.
  always_comb begin
    accShifted  = accSum >> SHIFT;
    candRaw     = accShifted[OUT_W-1:0];
    candFloored = (candRaw < FLOOR_V) ? FLOOR_V : candRaw;
    candEven    = {candFloored[OUT_W-1:1], 1'b0};
    absDiff     = (candFloored >= targetLen) ? (candFloored - targetLen)
                                             : (targetLen - candFloored);
    takeCand    = absDiff >= BAND_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      targetLen <= INIT_V;
      targetUpd <= 1'b0;
    end else begin
      targetUpd <= strobes.evaluate && takeCand;
      if (strobes.evaluate && takeCand) begin
        targetLen <= candEven;
      end
    end
  end

endmodule

// File: rtl/pot_length_filter.sv
module pot_length_filter #(
  parameter int unsigned ADC_W       = 10,
  parameter int unsigned LOG_SAMPLES = 8,
  parameter int unsigned OUT_W       = 16,
  parameter int unsigned MIN_LEN     = 'h0200,
  parameter int unsigned DEADBAND    = 'h0040,
  parameter int unsigned RESET_LEN   = 'h0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adcValid,
  input  logic [ADC_W-1:0] adcData,
  output logic [OUT_W-1:0] targetLen,
  output logic             targetUpd
);

  pot_length_pkg::ctlStrobes_t strobes;

  pot_length_ctrl #(
    .LOG_SAMPLES(LOG_SAMPLES)
  ) ctrlInst (
    .clk     (clk),
    .rst     (rst),
    .adcValid(adcValid),
    .strobes (strobes)
  );

  pot_length_dpath #(
    .ADC_W      (ADC_W),
    .LOG_SAMPLES(LOG_SAMPLES),
    .OUT_W      (OUT_W),
    .MIN_LEN    (MIN_LEN),
    .DEADBAND   (DEADBAND),
    .RESET_LEN  (RESET_LEN)
  ) dpathInst (
    .clk      (clk),
    .rst      (rst),
    .adcData  (adcData),
    .strobes  (strobes),
    .targetLen(targetLen),
    .targetUpd(targetUpd)
  );

endmodule

// File: rtl/pot_length_filter_chk.sv
module pot_length_filter_chk #(
  parameter int unsigned OUT_W    = 16,
  parameter int unsigned MIN_LEN  = 'h0200,
  parameter int unsigned DEADBAND = 'h0040
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] targetLen,
  input logic             targetUpd
);

  logic [OUT_W-1:0] prevTarget;
  logic [OUT_W-1:0] stepSize;

  always_ff @(posedge clk) begin
    if (rst) prevTarget <= targetLen;
    else     prevTarget <= targetLen;
  end

  always_comb begin
    stepSize = (targetLen >= prevTarget) ? (targetLen - prevTarget)
                                         : (prevTarget - targetLen);
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    targetUpd |=> !targetUpd);

  assert_change_flagged_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(targetLen) |-> targetUpd);

  assert_flag_means_change_R8: assert property (@(posedge clk) disable iff (rst)
    targetUpd |-> !$stable(targetLen));

  assert_even_write_R5: assert property (@(posedge clk) disable iff (rst)
    targetUpd |-> (targetLen[0] == 1'b0));

  assert_floor_kept_R3: assert property (@(posedge clk) disable iff (rst)
    targetLen >= OUT_W'(MIN_LEN));

  assert_deadband_step_R4: assert property (@(posedge clk) disable iff (rst)
    targetUpd |-> (stepSize >= OUT_W'(DEADBAND)));

endmodule

bind pot_length_filter pot_length_filter_chk #(
  .OUT_W   (OUT_W),
  .MIN_LEN (MIN_LEN),
  .DEADBAND(DEADBAND)
) chkInst (
  .clk      (clk),
  .rst      (rst),
  .targetLen(targetLen),
  .targetUpd(targetUpd)
);

// File: tb/tb_pot_length_filter.sv
module tb_pot_length_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adcValid = 1'b0;
  logic [9:0] adcData = '0;
  logic [15:0] targetLen;
  logic        targetUpd;

  int checks = 0;
  int errors = 0;
  int expTarget = 'h600;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pot_length_filter dut (
    .clk      (clk),
    .rst      (rst),
    .adcValid (adcValid),
    .adcData  (adcData),
    .targetLen(targetLen),
    .targetUpd(targetUpd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Requirement model: returns whether an update is expected; updates expTarget.
  function automatic bit modelBlock(input int sum);
    int cand = (sum >> 2) & 'hFFFF;
    int diff;
    if (cand < 'h200) cand = 'h200;
    diff = (cand >= expTarget) ? cand - expTarget : expTarget - cand;
    if (diff >= 'h40) begin
      expTarget = cand & 'hFFFE;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic sendOne(input int code);
    @(negedge clk);
    adcValid = 1'b1;
    adcData  = 10'(code);
    @(negedge clk);
    adcValid = 1'b0;
  endtask

  // 255 samples of v, then w; check result in the cycle after the update edge.
  task automatic runBlock(input int v, input int w, input string req);
    int sum = 0;
    bit upd;
    for (int i = 0; i < 256; i++) begin
      int s = (i == 255) ? w : v;
      sendOne(s);
      sum += s;
    end
    upd = modelBlock(sum);
    @(negedge clk);
    check(targetLen == 16'(expTarget), req, "target", targetLen, expTarget);
    check(targetUpd == upd, req, "update pulse", targetUpd, upd);
    @(negedge clk);
    check(targetUpd == 1'b0, "R8", "pulse one cycle", targetUpd, 0);
    check(targetLen == 16'(expTarget), req, "target held", targetLen, expTarget);
  endtask

  task automatic testReset();
    check(targetLen == 16'h0600, "R7", "reset target", targetLen, 'h600);
    check(targetUpd == 1'b0, "R7", "reset pulse", targetUpd, 0);
  endtask

  task automatic testPartial();  // R2: 255 strobes are not a block
    int sum = 0;
    bit upd;
    for (int i = 0; i < 255; i++) begin
      sendOne(30);
      sum += 30;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(targetLen == 16'(expTarget) && !targetUpd, "R2", "no early update",
            targetLen, expTarget);
    end
    sendOne(30);
    sum += 30;
    upd = modelBlock(sum);
    @(negedge clk);
    check(targetLen == 16'(expTarget) && targetUpd == upd, "R2", "256th strobe",
          targetLen, expTarget);
  endtask

  task automatic testContinuous();  // R9: strobe in evaluation cycle
    bit upd;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (i == 257) begin
        upd = modelBlock(256 * 100);
        check(targetLen == 16'(expTarget), "R9", "first block target",
              targetLen, expTarget);
        check(targetUpd == upd, "R9", "first block pulse", targetUpd, upd);
      end
      adcValid = 1'b1;
      adcData  = (i < 256) ? 10'd100 : 10'd200;
    end
    @(negedge clk);
    adcValid = 1'b0;
    upd = modelBlock(256 * 200);
    @(negedge clk);
    check(targetLen == 16'(expTarget), "R9", "second block target",
          targetLen, expTarget);
    check(targetUpd == upd, "R9", "second block pulse", targetUpd, upd);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    runBlock(16, 16, "R1");      // 0x400, move down from reset value
    runBlock(2, 2, "R3");        // 0x080 floored to 0x200
    runBlock(0, 0, "R3");        // floor equals stored: no change
    runBlock(9, 5, "R4");        // 0x23F: 0x3F above, held
    runBlock(9, 9, "R4");        // 0x240: exactly 0x40 above, taken
    runBlock(12, 16, "R5");      // 0x301 written as 0x300
    runBlock(11, 15, "R4");      // 0x2C1: 0x3F below, held
    runBlock(1023, 1023, "R1");  // full scale 0xFFC0; also R6 fresh sum
    runBlock(1023, 1023, "R6");  // same again, no update, fresh sum
    testPartial();
    testContinuous();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule